// File: doc/BRIEF.md
# Modem Control and Status Register Unit

This block holds the modem control register and the modem status register of a serial port. It takes four modem input lines: carrier detect, ring, data-set-ready and clear-to-send. It brings them into the local clock domain through a synchroniser and keeps their current levels. It also keeps a set of change flags that record which lines have moved since software last read the status register. A read returns the levels and the flags in one byte, and the flags are cleared by that read.

The control register drives the four modem output pins and holds a loopback switch. When loopback is on, the status lines are fed from the control bits instead of the pins, so software can test the change-flag path without a cable. The block also produces a modem-status interrupt request when any change flag is set and the interrupt enable is high. Prioritising this request against other interrupt sources is left to the surrounding logic.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status register reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control register reads 0x08, and the interrupt request is low.
- R2: A control write keeps wr_data[4:0] as data-terminal-ready (bit 0), request-to-send (bit 1), aux output 1 (bit 2), aux output 2 (bit 3) and loopback (bit 4). A control read returns those bits with bits 7:5 as zero, and the four output pins follow bits 3:0.
- R3: The status byte carries the line levels carrier (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). A change flag for carrier (bit 3), data-set-ready (bit 1) or clear-to-send (bit 0) is set when that line's level changes in either direction. Flags from separate changes accumulate until a read.
- R4: A status read returns the byte as it stood before the read edge and then clears bits 3:0. Bits 7:4 are left unchanged.
- R5: The ring flag (bit 2) is set only when ring falls from 1 to 0. It is never set by a rising ring line.
- R6: msi_irq is high exactly while msi_en is high and at least one of status bits 3:0 is set. It drops after a status read that clears the flags.
- R7: A change on an external line updates the status byte and the interrupt on the third rising edge after the change. Read data appears on rd_data at the rising edge that samples reg_rd.
- R8: In loopback the status levels follow the control register one edge after it is written: aux output 2 to carrier, aux output 1 to ring, request-to-send to clear-to-send, and data-terminal-ready to data-set-ready. Changes on the external lines then have no effect on the status byte or the interrupt.
- R9: A line change that reaches the status register on the same edge as a status read is not lost. The read returns the old byte, and the new change flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe; writes the control register when reg_sel is 0 |
| reg_rd | input | 1 | Read strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| ri_in | input | 1 | Ring line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| out1_out | output | 1 | Aux output 1 |
| out2_out | output | 1 | Aux output 2 |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
An external line change needs three rising edges to take effect: two synchroniser stages, then the status register. The bench changes a line at a falling edge and observes the effect after exactly three edges. Around the latency check it samples the interrupt after two edges, when it must still be low, and after three, when it must be high. A read takes one edge, and a control write reaches the loopback status one edge after the register itself. The coincident-read case starts a read two edges after a line change, so that the capture and the flag update fall on the same edge.

// File: rtl/msu_pkg.sv
package msu_pkg;
    localparam int REG_W  = 8;
    localparam int MCR_W  = 5;
    localparam int NLINE  = 4;

    // status levels, bit 3 down to bit 0 of this struct = byte bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    // change flags, byte bits 3:0
    typedef struct packed {
        logic ddcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } delta_t;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    typedef enum logic {SEL_MCR = 1'b0, SEL_MSR = 1'b1} sel_e;

    localparam mcr_t  MCR_RST  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
    localparam line_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    function automatic line_t loop_map(mcr_t m);
        line_t l;
        l.dcd = m.out2;
        l.ri  = m.out1;
        l.dsr = m.dtr;
        l.cts = m.rts;
        return l;
    endfunction

    function automatic delta_t edge_flags(line_t prev, line_t nxt);
        delta_t d;
        d.ddcd = prev.dcd ^ nxt.dcd;
        d.teri = prev.ri & ~nxt.ri;
        d.ddsr = prev.dsr ^ nxt.dsr;
        d.dcts = prev.cts ^ nxt.cts;
        return d;
    endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync #(
    parameter int          STAGES = 2,
    parameter int          W      = 4,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_V[i]}};
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[LAST];
    end
endmodule

// File: rtl/msu_ctrl.sv
module msu_ctrl
    import msu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [MCR_W-1:0] wdata,
    output mcr_t             mcr_q
);
    always_ff @(posedge clk) begin
        if (rst)     mcr_q <= MCR_RST;
        else if (wr) mcr_q <= mcr_t'(wdata);
    end

    // R2
    mcr_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> mcr_q == mcr_t'($past(wdata)));

    // R1
    mcr_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> mcr_q == MCR_RST);
endmodule

// File: rtl/msu_status.sv
module msu_status
    import msu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   loop,
    input  line_t  loop_src,
    input  line_t  ext,
    input  logic   rd_clr,
    output line_t  stat_q,
    output delta_t delta_q
);
    line_t  src;
    delta_t base;

    assign src  = loop ? loop_src : ext;
    assign base = rd_clr ? delta_t'('0) : delta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= LINE_RST;
            delta_q <= '0;
        end else begin
            stat_q  <= src;
            delta_q <= base | edge_flags(stat_q, src);
        end
    end

    logic [NLINE-1:0] dq_bits;
    assign dq_bits = delta_q;

    // R5
    teri_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_q.teri) |-> $fell(stat_q.ri));

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && src == stat_q) |=> dq_bits == '0);

    // R3
    delta_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> (dq_bits & $past(dq_bits)) == $past(dq_bits));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic       reg_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       msi_en,
    input  logic       dcd_in,
    input  logic       ri_in,
    input  logic       dsr_in,
    input  logic       cts_in,
    output logic       dtr_out,
    output logic       rts_out,
    output logic       out1_out,
    output logic       out2_out,
    output logic       msi_irq
);
    localparam int PAD_W = REG_W - MCR_W;

    mcr_t   mcr_q;
    line_t  ext_raw, ext_sync, stat_q;
    delta_t delta_q;
    logic   wr_mcr, rd_msr;
    logic [PAD_W-1:0] unused_wr_hi;

    assign unused_wr_hi = wr_data[REG_W-1:MCR_W];
    assign wr_mcr  = reg_wr && (sel_e'(reg_sel) == SEL_MCR);
    assign rd_msr  = reg_rd && (sel_e'(reg_sel) == SEL_MSR);
    assign ext_raw = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};

    msu_sync #(.STAGES(SYNC_STAGES), .W(NLINE), .RST_V(LINE_RST)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (ext_raw),
        .q   (ext_sync)
    );

    msu_ctrl ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_mcr),
        .wdata (wr_data[MCR_W-1:0]),
        .mcr_q (mcr_q)
    );

    msu_status stat_i (
        .clk      (clk),
        .rst      (rst),
        .loop     (mcr_q.loop),
        .loop_src (loop_map(mcr_q)),
        .ext      (ext_sync),
        .rd_clr   (rd_msr),
        .stat_q   (stat_q),
        .delta_q  (delta_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (reg_rd)
            rd_data <= (sel_e'(reg_sel) == SEL_MSR) ? {stat_q, delta_q}
                                                    : {{PAD_W{1'b0}}, mcr_q};
    end

    assign dtr_out  = mcr_q.dtr;
    assign rts_out  = mcr_q.rts;
    assign out1_out = mcr_q.out1;
    assign out2_out = mcr_q.out2;
    assign msi_irq  = msi_en && (delta_q != '0);

    // R8
    loop_map_chk: assert property (@(posedge clk) disable iff (rst)
        (mcr_q.loop && $past(mcr_q.loop)) |-> stat_q == loop_map($past(mcr_q)));

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        msi_irq |-> (msi_en && delta_q != '0));

    // R1
    msr_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (stat_q == LINE_RST && delta_q == '0));
endmodule

// File: tb/modem_status_unit_tb_top.sv
`timescale 1ns/1ps
module modem_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       msi_en = 1'b0;
    logic       dcd_in = 1'b1, ri_in = 1'b0, dsr_in = 1'b1, cts_in = 1'b1;
    logic       dtr_out, rts_out, out1_out, out2_out, msi_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_unit dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .msi_en(msi_en),
        .dcd_in(dcd_in), .ri_in(ri_in), .dsr_in(dsr_in), .cts_in(cts_in),
        .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out),
        .msi_irq(msi_irq)
    );

    // all tasks start and end at a falling edge
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_rd = 1'b1; reg_sel = sel;
        tick(1);
        reg_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = 1'b0; wr_data = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic lines(input logic c, input logic r, input logic s, input logic t);
        dcd_in = c; ri_in = r; dsr_in = s; cts_in = t;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b1, v); chk("R1 status after reset", v, 8'hB0);
        rd(1'b0, v); chk("R1 control after reset", v, 8'h08);
        chk("R1 irq after reset", {7'd0, msi_irq}, 8'h00);
    endtask

    task automatic t_mcr();
        logic [7:0] v;
        wr(8'hE7);
        rd(1'b0, v); chk("R2 control keeps low bits", v, 8'h07);
        chk("R2 output pins", {4'd0, out2_out, out1_out, rts_out, dtr_out}, 8'h07);
        wr(8'h08);
    endtask

    task automatic t_delta();
        logic [7:0] v;
        lines(1, 0, 1, 0); tick(3);
        rd(1'b1, v); chk("R3 cts change flag", v, 8'hA1);
        rd(1'b1, v); chk("R4 flags cleared by read", v, 8'hA0);
        lines(1, 0, 0, 0); tick(3);
        lines(0, 0, 0, 0); tick(3);
        rd(1'b1, v); chk("R3 flags accumulate", v, 8'h0A);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        lines(0, 1, 0, 0); tick(3);
        rd(1'b1, v); chk("R5 rising ring no flag", v, 8'h40);
        lines(0, 0, 0, 0); tick(3);
        rd(1'b1, v); chk("R5 falling ring flag", v, 8'h04);
        rd(1'b1, v); chk("R4 ring flag cleared", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        msi_en = 1'b0;
        lines(0, 0, 0, 1); tick(3);
        chk("R6 irq masked", {7'd0, msi_irq}, 8'h00);
        msi_en = 1'b1; tick(1);
        chk("R6 irq enabled", {7'd0, msi_irq}, 8'h01);
        rd(1'b1, v); chk("R6 read value", v, 8'h11);
        chk("R6 irq drops after read", {7'd0, msi_irq}, 8'h00);
    endtask

    task automatic t_latency();
        logic [7:0] v;
        lines(0, 0, 1, 1); tick(2);
        chk("R7 no irq after two edges", {7'd0, msi_irq}, 8'h00);
        tick(1);
        chk("R7 irq after three edges", {7'd0, msi_irq}, 8'h01);
        rd(1'b1, v); chk("R7 status after sync", v, 8'h32);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        wr(8'h19); tick(2);
        rd(1'b1, v);
        rd(1'b1, v); chk("R8 loop map dtr out2", v, 8'hA0);
        lines(1, 1, 0, 0); tick(3);
        chk("R8 external ignored irq", {7'd0, msi_irq}, 8'h00);
        rd(1'b1, v); chk("R8 external ignored status", v, 8'hA0);
        wr(8'h1E); tick(2);
        rd(1'b1, v); chk("R8 loop map rts out1 out2", v, 8'hD3);
        wr(8'h08); tick(3);
        rd(1'b1, v);
        rd(1'b1, v); chk("R8 external after loop exit", v, 8'hC0);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        lines(1, 1, 0, 1); tick(2);
        rd(1'b1, v); chk("R9 read returns old byte", v, 8'hC0);
        rd(1'b1, v); chk("R9 change kept", v, 8'hD1);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        t_reset();
        t_mcr();
        t_delta();
        t_ring();
        t_irq();
        t_latency();
        t_loop();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule